// File: doc/BRIEF.md
# Perceptual Relevance Metric Unit

This unit measures how much local detail each square tile of a picture holds, as one input to an adaptive downsampler. It accepts a raster stream of 8-bit luminance samples. Each sample carries the index of its tile within the current row of tiles, and a row of tiles is `TILE` lines of `TILE*NTILES` samples. For every tile the unit forms the absolute differences between horizontal and vertical neighbours that lie inside the same tile. It sorts each difference into one of five quanta, then averages the quanta over the non-zero ones only. That mean is rescaled onto the unit interval and reduced to one of five activity levels per axis.

The per-tile sums and counts are kept in small accumulator banks. Two pipelined fixed-point dividers, one per axis, are shared by all tiles of the row. Tiles complete from left to right, at least `TILE` accepted samples apart, so the dividers take them in turn. One result strobe leaves per tile, carrying both axis levels and the tile index.

Back-pressure rules: the unit never stalls its input. `in_ready` is high whenever reset is released, and a sample is taken on every rising edge with `in_valid` high. Gaps with `in_valid` low are allowed anywhere and have no effect. The result port is a plain strobe with no ready, so the consumer must take each `out_valid` pulse when it occurs.

Top module: `perc_rel_unit`

## Requirements
- R1: While reset is released `in_ready` is 1. A sample is consumed exactly on edges where `in_valid` is 1, and idle cycles between samples do not change any result.
- R2: A horizontal difference is formed between a sample and its left neighbour only when the sample's column offset inside its tile is non-zero. Pairs that straddle a tile edge give nothing.
- R3: A vertical difference is formed between a sample and the sample one line (`TILE*NTILES` samples) earlier only when the sample's line offset inside the tile row is non-zero. Nothing is formed across tile rows.
- R4: A difference d is quantized to the count of thresholds in {TH1,TH2,TH3,TH4} (defaults 4, 12, 28, 60) that are less than or equal to |d|, which gives a value from 0 to 4.
- R5: Per tile and axis, the unit keeps the sum S of the quanta and the count C of non-zero quanta. When C>0 the mean is Q = floor(S*1024/C) in unsigned 10.10 fixed point.
- R6: The level equals the number of boundaries 1024+3*LVk (defaults 1408, 2176, 2944, 3712) that are at or below Q, which snaps (Q-1)/3 onto points LVk/1024. When C=0 the level is 0. Levels are encoded 0 to 4 on 3 bits.
- R7: Exactly one single-cycle `out_valid` strobe is issued per tile. Tiles come in left-to-right order, with `out_tile` holding the index.
- R8: `out_valid` is registered on the 21st rising edge after the edge that accepts the tile's last sample (bottom-right corner).
- R9: A tile's accumulators are cleared when its totals go to the divider, so every row of tiles is measured independently.
- R10: An active-low asynchronous reset clears the accumulators and the position counters (next sample is line 0, column 0) and holds `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Unit accepts a sample (always high out of reset) |
| in_pix | input | 8 | Luminance sample |
| in_tile | input | TW ($clog2(NTILES), default 2) | Tile index of the sample within the row |
| out_valid | output | 1 | Result strobe for one tile |
| out_tile | output | TW | Index of the tile being reported |
| out_hlev | output | 3 | Horizontal activity level 0..4 |
| out_vlev | output | 3 | Vertical activity level 0..4 |

## Verification
Rows built from linear ramps with fixed horizontal and vertical steps give each tile one quantum on each axis. Those rows separate the five quantizer bins and show that the level mapping is right for uniform content, including descending ramps where the difference is negative. Tiles that are flat inside but differ sharply from their neighbours, and whole rows that jump in value from the row above, must report zero activity, which shows that tile edges and tile-row edges are excluded. Irregular content fed with idle gaps is compared against an independent average over the non-zero quanta, which tests the division and the zero-count rule. A reset in the middle of a row shows that partial totals are discarded.

// File: rtl/prm_pkg.sv
package prm_pkg;
  localparam int FRAC = 10;          // fraction bits of the mean
  localparam int QW   = 2 * FRAC;    // quotient width, one divider stage per bit
  localparam int LVW  = 3;           // activity level width
  typedef logic [LVW-1:0] lvl_t;
endpackage

// File: rtl/prm_quant.sv
module prm_quant #(
  parameter int TH1 = 4,
  parameter int TH2 = 12,
  parameter int TH3 = 28,
  parameter int TH4 = 60
) (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       en,
  output logic [2:0] q
);
  logic [7:0] mag;

  always_comb begin
    mag = (a >= b) ? (a - b) : (b - a);
    q   = '0;
    if (en) begin
      q = 3'(32'(mag) >= TH1) + 3'(32'(mag) >= TH2)
        + 3'(32'(mag) >= TH3) + 3'(32'(mag) >= TH4);
    end
  end
endmodule

// File: rtl/prm_divsnap.sv
module prm_divsnap
  import prm_pkg::*;
#(
  parameter int SW  = 6,
  parameter int CW  = 4,
  parameter int TW  = 2,
  parameter int LV1 = 128,
  parameter int LV2 = 384,
  parameter int LV3 = 640,
  parameter int LV4 = 896
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tile,
  input  logic [SW-1:0] in_sum,
  input  logic [CW-1:0] in_cnt,
  output logic          out_valid,
  output logic [TW-1:0] out_tile,
  output lvl_t          out_lev
);
  localparam logic [QW-1:0] B1 = QW'((1 << FRAC) + 3 * LV1);
  localparam logic [QW-1:0] B2 = QW'((1 << FRAC) + 3 * LV2);
  localparam logic [QW-1:0] B3 = QW'((1 << FRAC) + 3 * LV3);
  localparam logic [QW-1:0] B4 = QW'((1 << FRAC) + 3 * LV4);

  for (genvar i = 0; i <= QW; i++) begin : g_st
    logic          v;
    logic          z;
    logic [TW-1:0] tl;
    logic [CW-1:0] rm;
    logic [CW-1:0] dv;
    logic [QW-1:0] dd;
    logic [QW-1:0] qq;

    if (i == 0) begin : g_load
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v <= 1'b0;
        else        v <= in_valid;
      end
      always_ff @(posedge clk) begin
        z  <= (in_cnt == '0);
        tl <= in_tile;
        rm <= '0;
        dv <= (in_cnt == '0) ? CW'(1) : in_cnt;
        dd <= {{(QW-SW){1'b0}}, in_sum} << FRAC;
        qq <= '0;
      end
    end else begin : g_bit
      logic [CW:0] trial;
      logic [CW:0] diff;
      always_comb begin
        trial = {g_st[i-1].rm, g_st[i-1].dd[QW-i]};
        diff  = trial - {1'b0, g_st[i-1].dv};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v <= 1'b0;
        else        v <= g_st[i-1].v;
      end
      always_ff @(posedge clk) begin
        z  <= g_st[i-1].z;
        tl <= g_st[i-1].tl;
        dv <= g_st[i-1].dv;
        dd <= g_st[i-1].dd;
        if (trial >= {1'b0, g_st[i-1].dv}) begin
          rm <= diff[CW-1:0];
          qq <= g_st[i-1].qq | (QW'(1) << (QW - i));
        end else begin
          rm <= trial[CW-1:0];
          qq <= g_st[i-1].qq;
        end
      end
    end
  end

  lvl_t lev;
  always_comb begin
    lev = LVW'(g_st[QW].qq >= B1) + LVW'(g_st[QW].qq >= B2)
        + LVW'(g_st[QW].qq >= B3) + LVW'(g_st[QW].qq >= B4);
    if (g_st[QW].z) lev = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= g_st[QW].v;
  end

  always_ff @(posedge clk) begin
    out_tile <= g_st[QW].tl;
    out_lev  <= lev;
  end
endmodule

// File: rtl/perc_rel_unit.sv
module perc_rel_unit
  import prm_pkg::*;
#(
  parameter int TILE   = 4,
  parameter int NTILES = 4,
  parameter int TH1 = 4,
  parameter int TH2 = 12,
  parameter int TH3 = 28,
  parameter int TH4 = 60,
  parameter int LV1 = 128,
  parameter int LV2 = 384,
  parameter int LV3 = 640,
  parameter int LV4 = 896,
  localparam int TW = (NTILES > 1) ? $clog2(NTILES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_pix,
  input  logic [TW-1:0] in_tile,
  output logic          out_valid,
  output logic [TW-1:0] out_tile,
  output lvl_t          out_hlev,
  output lvl_t          out_vlev
);
  localparam int LINE  = TILE * NTILES;
  localparam int XW    = $clog2(LINE);
  localparam int OFFW  = $clog2(TILE);
  localparam int NDIFF = TILE * (TILE - 1);
  localparam int CW    = $clog2(NDIFF + 1);
  localparam int SW    = $clog2(4 * NDIFF + 1);

  logic [XW-1:0]   xpos;
  logic [OFFW-1:0] ypos;
  logic [7:0]      lbuf [LINE];
  logic            take, hen, ven, tile_end;
  logic [2:0]      qh, qv;
  logic [SW-1:0]   hsum [NTILES];
  logic [SW-1:0]   vsum [NTILES];
  logic [CW-1:0]   hcnt [NTILES];
  logic [CW-1:0]   vcnt [NTILES];
  logic [SW-1:0]   nhs, nvs;
  logic [CW-1:0]   nhc, nvc;

  assign in_ready = rst_n;
  assign take     = in_valid && in_ready;
  assign hen      = (xpos[OFFW-1:0] != '0);
  assign ven      = (ypos != '0);
  assign tile_end = (ypos == OFFW'(TILE - 1)) && (xpos[OFFW-1:0] == OFFW'(TILE - 1));

  prm_quant #(.TH1(TH1), .TH2(TH2), .TH3(TH3), .TH4(TH4)) u_qh (
    .a(in_pix), .b(lbuf[0]), .en(hen), .q(qh)
  );
  prm_quant #(.TH1(TH1), .TH2(TH2), .TH3(TH3), .TH4(TH4)) u_qv (
    .a(in_pix), .b(lbuf[LINE-1]), .en(ven), .q(qv)
  );

  always_comb begin
    nhs = hsum[in_tile] + SW'(qh);
    nvs = vsum[in_tile] + SW'(qv);
    nhc = hcnt[in_tile] + CW'(qh != '0);
    nvc = vcnt[in_tile] + CW'(qv != '0);
  end

  // raster position inside the current row of tiles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xpos <= '0;
      ypos <= '0;
    end else if (take) begin
      if (xpos == XW'(LINE - 1)) begin
        xpos <= '0;
        ypos <= (ypos == OFFW'(TILE - 1)) ? '0 : ypos + 1'b1;
      end else begin
        xpos <= xpos + 1'b1;
      end
    end
  end

  // one-line delay; lbuf[0] is the left neighbour, lbuf[LINE-1] the one above
  always_ff @(posedge clk) begin
    if (take) begin
      lbuf[0] <= in_pix;
      for (int k = 1; k < LINE; k++) lbuf[k] <= lbuf[k-1];
    end
  end

  // per-tile accumulators, emptied when the tile is handed to the dividers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTILES; t++) begin
        hsum[t] <= '0; vsum[t] <= '0; hcnt[t] <= '0; vcnt[t] <= '0;
      end
    end else if (take) begin
      if (tile_end) begin
        hsum[in_tile] <= '0; vsum[in_tile] <= '0;
        hcnt[in_tile] <= '0; vcnt[in_tile] <= '0;
      end else begin
        hsum[in_tile] <= nhs; vsum[in_tile] <= nvs;
        hcnt[in_tile] <= nhc; vcnt[in_tile] <= nvc;
      end
    end
  end

  logic          launch;
  logic          vout_unused;
  logic [TW-1:0] vtile_unused;
  assign launch = take && tile_end;

  prm_divsnap #(.SW(SW), .CW(CW), .TW(TW),
                .LV1(LV1), .LV2(LV2), .LV3(LV3), .LV4(LV4)) u_hdiv (
    .clk(clk), .rst_n(rst_n), .in_valid(launch), .in_tile(in_tile),
    .in_sum(nhs), .in_cnt(nhc),
    .out_valid(out_valid), .out_tile(out_tile), .out_lev(out_hlev)
  );
  prm_divsnap #(.SW(SW), .CW(CW), .TW(TW),
                .LV1(LV1), .LV2(LV2), .LV3(LV3), .LV4(LV4)) u_vdiv (
    .clk(clk), .rst_n(rst_n), .in_valid(launch), .in_tile(in_tile),
    .in_sum(nvs), .in_cnt(nvc),
    .out_valid(vout_unused), .out_tile(vtile_unused), .out_lev(out_vlev)
  );
endmodule

// File: rtl/prm_chk.sv
module prm_chk #(
  parameter int TILE   = 4,
  parameter int NTILES = 4,
  parameter int TW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [TW-1:0] out_tile,
  input logic [2:0]    out_hlev,
  input logic [2:0]    out_vlev
);
  localparam int LINE = TILE * NTILES;
  localparam int LAT  = 21;

  int unsigned   cx, cy;
  logic [LAT:0]  hist;
  logic [TW-1:0] nxt;
  logic          corner;

  assign corner = in_valid && in_ready && (cy == TILE - 1) && ((cx % TILE) == TILE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx <= 0; cy <= 0; hist <= '0; nxt <= '0;
    end else begin
      hist <= {hist[LAT-1:0], corner};
      if (out_valid) nxt <= (32'(nxt) == NTILES - 1) ? '0 : nxt + 1'b1;
      if (in_valid && in_ready) begin
        if (cx == LINE - 1) begin
          cx <= 0;
          cy <= (cy == TILE - 1) ? 0 : cy + 1;
        end else begin
          cx <= cx + 1;
        end
      end
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT]);
  // R7
  tile_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tile == nxt);
  // R7
  lone_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hlev <= 3'd4) && (out_vlev <= 3'd4));
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind perc_rel_unit prm_chk #(.TILE(TILE), .NTILES(NTILES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_tile(out_tile),
  .out_hlev(out_hlev), .out_vlev(out_vlev)
);

// File: tb/sim_perc_rel_unit.sv
`timescale 1ns/1ps
module sim_perc_rel_unit;
  localparam int TILE = 4;
  localparam int NT   = 4;
  localparam int LINE = TILE * NT;
  localparam int TH [4] = '{4, 12, 28, 60};
  localparam int BD [4] = '{1408, 2176, 2944, 3712};
  // base, hstep, vstep, descending, expected hlev, expected vlev
  localparam int VEC [6][6] = '{
    '{10,  0,  0, 0, 0, 0},
    '{0,   5, 15, 0, 0, 1},
    '{0,  30,  0, 0, 3, 0},
    '{0,   0, 70, 0, 0, 4},
    '{255,15, 30, 1, 1, 3},
    '{0,  70,  5, 0, 4, 0}
  };

  logic       clk = 0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_pix;
  logic [1:0] in_tile;
  logic       out_valid;
  logic [1:0] out_tile;
  logic [2:0] out_hlev, out_vlev;
  logic       mark_last;

  always #10 clk = ~clk;

  perc_rel_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_tile(in_tile), .out_valid(out_valid),
    .out_tile(out_tile), .out_hlev(out_hlev), .out_vlev(out_vlev)
  );

  int pix [TILE][LINE];
  int eh [1024], ev [1024], et [1024];
  int ewp = 0, erp = 0;
  int checks = 0, fails = 0;

  // monitor-owned capture
  int nc = 0, lwp = 0, lrp = 0, cwp = 0;
  int lat_q [1024];
  int ch [1024], cv [1024], ct [1024], cl [1024];

  always @(negedge clk) begin
    nc = nc + 1;
    if (rst_n && in_valid && mark_last) begin
      lat_q[lwp] = nc;
      lwp = lwp + 1;
    end
    if (rst_n && out_valid) begin
      ch[cwp] = int'(out_hlev);
      cv[cwp] = int'(out_vlev);
      ct[cwp] = int'(out_tile);
      cl[cwp] = (lrp < lwp) ? nc - lat_q[lrp] : -1;
      lrp = lrp + 1;
      cwp = cwp + 1;
    end
  end

  initial begin
    #(20ns * 100000);
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int quant(input int a, input int b);
    int d = (a > b) ? a - b : b - a;
    int q = 0;
    for (int k = 0; k < 4; k++) if (d >= TH[k]) q++;
    return q;
  endfunction

  function automatic int level(input int s, input int c);
    int q, l = 0;
    if (c == 0) return 0;
    q = (s * 1024) / c;
    for (int k = 0; k < 4; k++) if (q >= BD[k]) l++;
    return l;
  endfunction

  task automatic push_const(input int h, input int v);
    for (int t = 0; t < NT; t++) begin
      eh[ewp] = h; ev[ewp] = v; et[ewp] = t; ewp++;
    end
  endtask

  // independent model: R2..R6
  task automatic push_model();
    for (int t = 0; t < NT; t++) begin
      int sh = 0, shc = 0, sv = 0, svc = 0;
      for (int r = 0; r < TILE; r++) begin
        for (int c = 0; c < TILE; c++) begin
          int x = t * TILE + c;
          if (c > 0) begin
            int q = quant(pix[r][x], pix[r][x-1]);
            sh += q; if (q != 0) shc++;
          end
          if (r > 0) begin
            int q = quant(pix[r][x], pix[r-1][x]);
            sv += q; if (q != 0) svc++;
          end
        end
      end
      eh[ewp] = level(sh, shc); ev[ewp] = level(sv, svc); et[ewp] = t; ewp++;
    end
  endtask

  task automatic fill_ramp(input int base, input int h, input int v, input int down);
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++)
        pix[r][c] = down ? base - (c % TILE) * h - r * v : base + (c % TILE) * h + r * v;
  endtask

  task automatic drive_lines(input int nlines, input bit gaps);
    for (int r = 0; r < nlines; r++) begin
      for (int c = 0; c < LINE; c++) begin
        if (gaps && ((r * 7 + c) % 5 == 0)) begin
          in_valid = 0;
          in_pix = 8'hAA;
          @(posedge clk); #2;
        end
        in_valid  = 1;
        in_pix    = 8'(pix[r][c]);
        in_tile   = 2'(c / TILE);
        mark_last = (r == TILE - 1) && (c % TILE == TILE - 1);
        @(posedge clk); #2;
        in_valid  = 0;
        mark_last = 0;
      end
    end
  endtask

  task automatic drain_compare(input string tag);
    repeat (40) @(posedge clk);
    #2;
    chk(cwp == ewp, "R7 result count", cwp, ewp);
    for (int i = erp; i < ewp && i < cwp; i++) begin
      chk(ct[i] == et[i], "R7 tile order", ct[i], et[i]);
      chk(ch[i] == eh[i], {"R5/R6 horizontal level ", tag}, ch[i], eh[i]);
      chk(cv[i] == ev[i], {"R5/R6 vertical level ", tag}, cv[i], ev[i]);
      // registered 21 edges after the accepting edge: 22 falling edges apart
      chk(cl[i] == 22, "R8 latency", cl[i], 22);
    end
    erp = ewp;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_pix = 0; in_tile = 0; mark_last = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid == 0, "R10 reset out_valid", int'(out_valid), 0);
    rst_n = 1;
    @(posedge clk); #2;
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);

    // table walk: R4, R5, R6 on uniform content
    for (int i = 0; i < 6; i++) begin
      fill_ramp(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      push_const(VEC[i][4], VEC[i][5]);
      drive_lines(TILE, 0);
    end
    drain_compare("table");

    // R2, R3, R9: tiles flat inside, steps only across tile and row edges
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = 20 + (c / TILE) * 70;
    push_const(0, 0);
    drive_lines(TILE, 0);
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = 250 - (c / TILE) * 60;
    push_const(0, 0);
    drive_lines(TILE, 0);
    drain_compare("edges");

    // R1, R5, R6: irregular content with idle gaps, model expectation
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = (c * 37 + r * 91 + c * r * 13) & 255;
    push_model();
    drive_lines(TILE, 1);
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = ((c % TILE) == 3 && r == 2) ? 200 : 50 + ((c * 5) % 9);
    push_model();
    drive_lines(TILE, 1);
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = (c * 29 + r * 101 + 7) & 255;
    push_model();
    drive_lines(TILE, 0);
    drain_compare("model");

    // R10: reset in the middle of a row drops partial totals
    for (int r = 0; r < TILE; r++)
      for (int c = 0; c < LINE; c++) pix[r][c] = (c * 61 + r * 17) & 255;
    drive_lines(2, 0);
    rst_n = 0;
    @(posedge clk); #2;
    chk(out_valid == 0, "R10 out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(posedge clk); #2;
    fill_ramp(VEC[4][0], VEC[4][1], VEC[4][2], VEC[4][3]);
    push_const(VEC[4][4], VEC[4][5]);
    drive_lines(TILE, 0);
    drain_compare("after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule